// File: doc/BRIEF.md
# Pad Pull Sequencer

The block keeps a two-bit pull setting for every pad of a parameterised pin set (54 by default) and drives those settings toward the pad ring. Software never addresses a pin's setting directly. It writes one shared pull code into a control register, waits, and then raises the pin's bit in a clock-mask register. A pin takes the shared code on the rising edge of its mask bit. Software then waits again and lowers the mask.

Both waits are enforced in hardware. If a mask bit rises before the code has settled for the hold window, or falls before the hold window has passed since the last rise, a sticky error flag is raised. A pin whose bit rose too early keeps its old setting. The applied settings are not readable through the write port. They appear only on the pad-side output.

Top module: `pull_seq`

## Requirements
- R1: After reset every pin's pull setting equals the RESET_PULL parameter and hold_err is 0. All mask bits reset to 0, so the first mask write after reset that sets a bit is a rising edge.
- R2: A write to address 0x94 stores wr_data[1:0] as the shared code: 0 means no pull, 1 means pull-down and 2 means pull-up. Pin i drives its setting on pull_state[2i+1:2i] with the same encoding.
- R3: Mask bank 0 is at address 0x98, where bit i belongs to pin i (pins 0 to 31). Bank 1 is at 0x9C, where bit i belongs to pin 32+i. A write replaces the whole bank. A pin whose bit goes from 0 to 1 takes the shared code in that write cycle, provided the write comes HOLD_CYCLES or more cycles after the last control write.
- R4: A pin whose mask bit does not go from 0 to 1 keeps its setting. This includes a bit that is held high while a new code is written.
- R5: A latched code of 3 is applied as 0 (no pull). No pin ever drives 3.
- R6: A mask bit that rises fewer than HOLD_CYCLES cycles after the last control write leaves its pin unchanged and sets hold_err.
- R7: A mask bit that falls fewer than HOLD_CYCLES cycles after the last rising mask bit sets hold_err. The setting that was latched on the rise stays.
- R8: Once set, hold_err stays 1 until reset, whatever writes follow.
- R9: A write to any address other than 0x94, 0x98 or 0x9C changes neither the pull settings nor hold_err.
- R10: A gap of exactly HOLD_CYCLES cycles is accepted. A gap of HOLD_CYCLES-1 cycles is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| pull_state | output | 2*NUM_PINS | Applied pull setting, two bits per pin |
| hold_err | output | 1 | Sticky timing-violation flag |

## Verification
A table of single-pin programming runs covers the first and last pins of each bank, every code value including the reserved one, and a pin rewritten with a new code. This separates bank and bit decoding from the latching itself. Multi-bit mask writes and a mask held high across a code change show that only pins with a 0-to-1 transition move. The wait rules are probed at gaps of exactly HOLD_CYCLES and one cycle less, once on the rising side and once on the falling side. A legal run that follows a violation shows that the error flag is sticky, while the legal latch still takes effect.

// File: rtl/pull_seq.sv
module pull_seq #(
  parameter int          NUM_PINS    = 54,
  parameter int          HOLD_CYCLES = 150,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter logic [1:0]  RESET_PULL  = 2'd0,
  parameter logic [7:0]  CTRL_ADDR   = 8'h94,
  parameter logic [7:0]  MASK_ADDR   = 8'h98
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [2*NUM_PINS-1:0] pull_state,
  output logic                  hold_err
);
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int CNT_W     = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(HOLD_CYCLES - 1);

  logic [1:0]          code_q;
  logic [CNT_W-1:0]    code_age, mask_age;
  logic [NUM_PINS-1:0] mask_q, mask_d, rise, fall;
  logic                ctrl_wr, code_ok, early_rise, early_fall;
  logic [1:0]          eff_code;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign code_ok  = (code_age == LIM);
  assign eff_code = (code_q == 2'd3) ? 2'd0 : code_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * DATA_W;
    localparam int W  = (NUM_PINS - LO < DATA_W) ? NUM_PINS - LO : DATA_W;
    localparam logic [ADDR_W-1:0] BA = ADDR_W'(MASK_ADDR + 4 * b);
    assign mask_d[LO +: W] = (wr_en && wr_addr == BA) ? wr_data[W-1:0] : mask_q[LO +: W];
  end

  assign rise       = mask_d & ~mask_q;
  assign fall       = mask_q & ~mask_d;
  assign early_rise = (|rise) && !code_ok;
  assign early_fall = (|fall) && (mask_age != LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= 2'd0;
      code_age <= LIM;
      mask_age <= LIM;
      mask_q   <= '0;
      hold_err <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (ctrl_wr) begin
        code_q   <= wr_data[1:0];
        code_age <= '0;
      end else if (code_age != LIM) begin
        code_age <= code_age + 1'b1;
      end
      if (|rise)                mask_age <= '0;
      else if (mask_age != LIM) mask_age <= mask_age + 1'b1;
      if (early_rise || early_fall) hold_err <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] pull_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pull_q <= RESET_PULL;
      else if (rise[i] && code_ok) pull_q <= eff_code;
    end
    assign pull_state[2*i +: 2] = pull_q;
  end
endmodule

// File: rtl/pull_seq_chk.sv
module pull_seq_chk #(
  parameter int         NUM_PINS  = 54,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] CTRL_ADDR = 8'h94,
  parameter logic [7:0] MASK_ADDR = 8'h98
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [2*NUM_PINS-1:0] pull_state,
  input logic                  hold_err
);
  logic mask_wr, known_wr;
  assign mask_wr  = wr_en && (wr_addr == ADDR_W'(MASK_ADDR) || wr_addr == ADDR_W'(MASK_ADDR + 8'd4));
  assign known_wr = mask_wr || (wr_en && wr_addr == ADDR_W'(CTRL_ADDR));

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_err |=> hold_err); // R8

  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pull_state)); // R4

  AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !known_wr) |=> ($stable(pull_state) && $stable(hold_err))); // R9

  AST_ERR_FROM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_err) |-> $past(mask_wr)); // R6

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        AST_NO_RESERVED: assert (pull_state[2*i +: 2] != 2'd3); // R5
      end
    end
  end
endmodule

bind pull_seq pull_seq_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .pull_state(pull_state), .hold_err(hold_err)
);

// File: tb/test_pull_seq.sv
module test_pull_seq;
  localparam int         PINS = 54;
  localparam int         HOLD = 150;
  localparam logic [1:0] RST  = 2'd2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [2*PINS-1:0] pull_state;
  logic            hold_err;

  int   checks = 0, errors = 0;
  bit   done = 0;
  logic [1:0] exp_pull [PINS];

  // {pin[5:0], code[1:0]}
  localparam logic [7:0] VEC [8] = '{
    {6'd0, 2'd1}, {6'd31, 2'd2}, {6'd32, 2'd1}, {6'd53, 2'd2},
    {6'd17, 2'd3}, {6'd40, 2'd0}, {6'd0, 2'd2}, {6'd53, 2'd3}
  };

  pull_seq #(.NUM_PINS(PINS), .HOLD_CYCLES(HOLD), .RESET_PULL(RST)) i_pull_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pull_state(pull_state), .hold_err(hold_err)
  );

  always #4 clk = ~clk;

  task automatic check_vec(input string tag);
    logic [2*PINS-1:0] e;
    for (int i = 0; i < PINS; i++) e[2*i +: 2] = exp_pull[i];
    checks++;
    if (pull_state !== e) begin
      errors++;
      $display("FAIL %s pull_state actual=%h expected=%h", tag, pull_state, e);
    end
  endtask

  task automatic check_err(input logic exp, input string tag);
    checks++;
    if (hold_err !== exp) begin
      errors++;
      $display("FAIL %s hold_err actual=%b expected=%b", tag, hold_err, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // next wr lands exactly k cycles after the previous one
  task automatic after(input int k);
    repeat (k - 2) @(negedge clk);
  endtask

  task automatic prog(input int pin, input logic [1:0] code, input int ga, input int gb);
    logic [7:0] a;
    a = (pin < 32) ? 8'h98 : 8'h9C;
    wr(8'h94, {30'd0, code});
    after(ga);
    wr(a, 32'd1 << (pin % 32));
    if (ga >= HOLD) exp_pull[pin] = (code == 2'd3) ? 2'd0 : code;
    after(gb);
    wr(a, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < PINS; i++) exp_pull[i] = RST;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_vec("R1 reset value");
    check_err(1'b0, "R1 reset flag");

    for (int v = 0; v < 8; v++) begin
      prog(int'(VEC[v][7:2]), VEC[v][1:0], HOLD, HOLD);
      check_vec($sformatf("R3/R2/R5 vector %0d", v));
      check_err(1'b0, $sformatf("R3 vector %0d flag", v));
    end

    // R4: several pins at once, others untouched
    wr(8'h94, 32'd2); after(HOLD);
    wr(8'h98, 32'h0000_000E); exp_pull[1] = 2; exp_pull[2] = 2; exp_pull[3] = 2;
    after(HOLD); wr(8'h98, 32'd0);
    check_vec("R4 multi-pin");

    // R4: bit held high across a code change does not relatch
    wr(8'h94, 32'd1); after(HOLD);
    wr(8'h98, 32'h20); exp_pull[5] = 1;
    after(HOLD); wr(8'h94, 32'd3); after(HOLD);
    wr(8'h98, 32'h60); exp_pull[6] = 0;
    after(HOLD); wr(8'h98, 32'd0);
    check_vec("R4 held mask");
    check_err(1'b0, "R4 held mask flag");

    // R9: other addresses ignored
    wr(8'hA0, 32'hFFFF_FFFF); wr(8'h99, 32'hFFFF_FFFF); wr(8'h90, 32'hFFFF_FFFF);
    check_vec("R9 foreign address");
    check_err(1'b0, "R9 flag");

    // R10 accepted boundary
    prog(10, 2'd1, HOLD, HOLD);
    check_vec("R10 exact gap");
    check_err(1'b0, "R10 exact gap flag");

    // R6 / R10 one cycle early
    prog(11, 2'd1, HOLD - 1, HOLD);
    check_vec("R6 early rise pin unchanged");
    check_err(1'b1, "R6 early rise flag");

    // R8 sticky across a legal run
    prog(12, 2'd1, HOLD, HOLD);
    check_vec("R8 legal after error");
    check_err(1'b1, "R8 sticky");

    do_reset();
    check_vec("R1 second reset");
    check_err(1'b0, "R1 second reset flag");

    // R7 early fall
    prog(20, 2'd1, HOLD, HOLD - 1);
    check_vec("R7 latched value kept");
    check_err(1'b1, "R7 early fall flag");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule